// File: doc/BRIEF.md
# Read-Data Separator Phase Comparator

This block is the phase-detecting front end of a floppy read-data separator. On every leading (falling) edge of the active-low raw read pulse it measures how far that edge lies from the most recent rising edge of the recovery-clock window. Both inputs are resynchronised and measured in system clocks. The window is split into three sub-regions of equal length. An edge in the first region asks the VCO to speed up. An edge in the last region asks it to slow down. An edge in the middle asks for nothing.

The two requests leave the block as pump outputs. Each is a value bit plus an output-enable, so that the tri-state behaviour of the real pins can be checked in simulation. The pump-up output, when driven, drives 1. The pump-down output, when driven, drives 0. When the two are tied together they form one correction line: high means faster, low means slower, and floating means hold. A request stays driven for a fixed number of system clocks and is then released.

The comparator only works while the separator is allowed to run. This means the inhibit line (VFO enable or write fault) is low, the write gate is low, and the active-low read gate is asserted. The analog VCO, the bias divider and the loop filter are outside this block.

Top module: `dsep_phase_cmp`

## Requirements
- R1: After a synchronous reset, both output-enables are 0, `up_val` is 0 and `dn_val` is 1.
- R2: Window phase D is the number of system clocks from the rising edge of `win_clk` to the falling edge of `rdat_n`. Both inputs pass through the same delay, and D is 0 when the two edges coincide. When D < SUB_LEN, pump-up is driven with value 1 and pump-down stays released.
- R3: When D >= 2*SUB_LEN, pump-down is driven with value 0 and pump-up stays released. This includes edges beyond the nominal window length of 3*SUB_LEN, where the phase counter saturates instead of wrapping.
- R4: When SUB_LEN <= D < 2*SUB_LEN, neither output is driven.
- R5: A request becomes visible SYNC_STAGES+1 clocks after the input edge is applied. It then stays driven for exactly PULSE_LEN clocks before both outputs are released.
- R6: While `sep_inhibit` or `write_gate` is high, read edges drive no output.
- R7: While `rgate_n` is high (read gate not asserted), read edges drive no output.
- R8: Raising `sep_inhibit` while a request is being driven releases that output on the next clock edge.
- R9: The two outputs are never driven in the same cycle. The tied line therefore reads 1 for pump-up, 0 for pump-down, and is floating otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rdat_n | input | 1 | Raw read-data pulse, active low; its falling edge is measured |
| win_clk | input | 1 | Recovery-clock window; its rising edge starts a window |
| rgate_n | input | 1 | Read gate, active low; must be low for any request |
| sep_inhibit | input | 1 | VFO-enable / write-fault line; high stops the comparator |
| write_gate | input | 1 | Write gate; high stops the comparator |
| up_val | output | 1 | Pump-up value, 1 while driven |
| up_oe | output | 1 | Pump-up output-enable |
| dn_val | output | 1 | Pump-down value, 0 while driven |
| dn_oe | output | 1 | Pump-down output-enable |

## Verification
The bench builds the block with SUB_LEN = 4, PULSE_LEN = 3 and SYNC_STAGES = 2. With these values each sub-region is only four clocks wide, so the edges of each region (phases 0, 3, 4, 7, 8) and a phase far past the 12-clock saturation point can all be hit with short, exact delays. A three-clock request is long enough to raise the inhibit line in the middle of one, and short enough that every request ends well before the next trial starts.

// File: rtl/dsep_pkg.sv
package dsep_pkg;

  typedef enum logic [1:0] {
    PH_EARLY  = 2'd0,
    PH_CENTRE = 2'd1,
    PH_LATE   = 2'd2
  } phase_cls_t;

  // Split a window into three equal regions of sub_len clocks each.
  function automatic phase_cls_t classify(input int unsigned phase,
                                          input int unsigned sub_len);
    if (phase < sub_len)          return PH_EARLY;
    else if (phase < 2 * sub_len) return PH_CENTRE;
    else                          return PH_LATE;
  endfunction

endpackage

// File: rtl/dsep_edge_det.sv
module dsep_edge_det #(
  parameter int STAGES  = 2,
  parameter bit FALLING = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic edge_o
);
  localparam logic IDLE = FALLING;

  logic [STAGES-1:0] sh;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= {STAGES{IDLE}};
      prev <= IDLE;
    end else begin
      sh   <= STAGES'({sh, din});
      prev <= sh[STAGES-1];
    end
  end

  generate
    if (FALLING) begin : g_fall
      assign edge_o = prev & ~sh[STAGES-1];
    end else begin : g_rise
      assign edge_o = ~prev & sh[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/dsep_win_timer.sv
module dsep_win_timer #(
  parameter int SUB_LEN = 8,
  parameter int CNT_W   = $clog2(3 * SUB_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             win_edge,
  output logic [CNT_W-1:0] phase_o
);
  localparam logic [CNT_W-1:0] MAXC = CNT_W'(3 * SUB_LEN);

  logic [CNT_W-1:0] cnt;

  // Counter reads 1 one clock after the window edge; the edge cycle itself is phase 0.
  always_ff @(posedge clk) begin
    if (rst)           cnt <= MAXC;
    else if (win_edge) cnt <= CNT_W'(1);
    else if (cnt != MAXC) cnt <= cnt + CNT_W'(1);
  end

  assign phase_o = win_edge ? '0 : cnt;

endmodule

// File: rtl/dsep_pump_drv.sv
module dsep_pump_drv
  import dsep_pkg::*;
#(
  parameter int PULSE_LEN = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic       hit,
  input  phase_cls_t cls,
  output logic       up_val,
  output logic       up_oe,
  output logic       dn_val,
  output logic       dn_oe
);
  localparam int HOLD_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;

  logic [HOLD_W-1:0] hold;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      up_oe  <= 1'b0;
      up_val <= 1'b0;
      dn_oe  <= 1'b0;
      dn_val <= 1'b1;
      hold   <= '0;
    end else if (hit) begin
      hold   <= HOLD_W'(PULSE_LEN - 1);
      up_oe  <= (cls == PH_EARLY);
      up_val <= (cls == PH_EARLY);
      dn_oe  <= (cls == PH_LATE);
      dn_val <= (cls != PH_LATE);
    end else if (up_oe || dn_oe) begin
      if (hold == '0) begin
        up_oe  <= 1'b0;
        up_val <= 1'b0;
        dn_oe  <= 1'b0;
        dn_val <= 1'b1;
      end else begin
        hold <= hold - HOLD_W'(1);
      end
    end
  end

endmodule

// File: rtl/dsep_phase_cmp.sv
module dsep_phase_cmp
  import dsep_pkg::*;
#(
  parameter int SUB_LEN     = 8,
  parameter int PULSE_LEN   = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rdat_n,
  input  logic win_clk,
  input  logic rgate_n,
  input  logic sep_inhibit,
  input  logic write_gate,
  output logic up_val,
  output logic up_oe,
  output logic dn_val,
  output logic dn_oe
);
  localparam int CNT_W = $clog2(3 * SUB_LEN + 1);

  logic             data_fall;
  logic             win_rise;
  logic [CNT_W-1:0] phase;
  logic             enable;
  logic             edge_ok;
  phase_cls_t       cls;

  dsep_edge_det #(.STAGES(SYNC_STAGES), .FALLING(1'b1)) u_data_edge (
    .clk(clk), .rst(rst), .din(rdat_n), .edge_o(data_fall)
  );

  dsep_edge_det #(.STAGES(SYNC_STAGES), .FALLING(1'b0)) u_win_edge (
    .clk(clk), .rst(rst), .din(win_clk), .edge_o(win_rise)
  );

  dsep_win_timer #(.SUB_LEN(SUB_LEN), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .win_edge(win_rise), .phase_o(phase)
  );

  assign enable  = ~sep_inhibit & ~write_gate & ~rgate_n;
  assign edge_ok = data_fall & enable;
  assign cls     = classify(int'(phase), SUB_LEN);

  dsep_pump_drv #(.PULSE_LEN(PULSE_LEN)) u_drv (
    .clk(clk), .rst(rst), .enable(enable), .hit(data_fall), .cls(cls),
    .up_val(up_val), .up_oe(up_oe), .dn_val(dn_val), .dn_oe(dn_oe)
  );

endmodule

// File: rtl/dsep_phase_cmp_chk.sv
module dsep_phase_cmp_chk #(
  parameter int PULSE_LEN = 6
) (
  input logic clk,
  input logic rst,
  input logic rgate_n,
  input logic sep_inhibit,
  input logic write_gate,
  input logic edge_ok,
  input logic up_val,
  input logic up_oe,
  input logic dn_val,
  input logic dn_oe
);
  int run;

  always_ff @(posedge clk) begin
    if (rst)                 run <= 0;
    else if (edge_ok)        run <= 0;
    else if (up_oe || dn_oe) run <= run + 1;
    else                     run <= 0;
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!up_oe && !dn_oe));

  assert_up_drives_one_R2: assert property (@(posedge clk) disable iff (rst)
    up_oe |-> up_val);

  assert_dn_drives_zero_R3: assert property (@(posedge clk) disable iff (rst)
    dn_oe |-> !dn_val);

  assert_hold_bounded_R5: assert property (@(posedge clk) disable iff (rst)
    (up_oe || dn_oe) |-> (run < PULSE_LEN));

  assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (sep_inhibit || write_gate) |=> (!up_oe && !dn_oe));

  assert_gate_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    rgate_n |=> (!up_oe && !dn_oe));

  assert_release_on_inhibit_R8: assert property (@(posedge clk) disable iff (rst)
    (up_oe && sep_inhibit) |=> !up_oe);

  assert_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    $countones({up_oe, dn_oe}) <= 1);

endmodule

bind dsep_phase_cmp dsep_phase_cmp_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .rst(rst), .rgate_n(rgate_n), .sep_inhibit(sep_inhibit),
  .write_gate(write_gate), .edge_ok(edge_ok), .up_val(up_val),
  .up_oe(up_oe), .dn_val(dn_val), .dn_oe(dn_oe)
);

// File: tb/dsep_phase_cmp_bench.sv
module dsep_phase_cmp_bench;
  localparam int SUB = 4;
  localparam int PL  = 3;
  localparam int SS  = 2;
  localparam int LAT = SS + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rdat_n = 1'b1, win_clk = 1'b0, rgate_n = 1'b0;
  logic sep_inhibit = 1'b0, write_gate = 1'b0;
  logic up_val, up_oe, dn_val, dn_oe;

  always #2 clk = ~clk;

  dsep_phase_cmp #(.SUB_LEN(SUB), .PULSE_LEN(PL), .SYNC_STAGES(SS)) u_dsep_phase_cmp (
    .clk(clk), .rst(rst), .rdat_n(rdat_n), .win_clk(win_clk), .rgate_n(rgate_n),
    .sep_inhibit(sep_inhibit), .write_gate(write_gate),
    .up_val(up_val), .up_oe(up_oe), .dn_val(dn_val), .dn_oe(dn_oe)
  );

  typedef struct {
    int    start;
    int    kind;   // 1 = pump-up, 2 = pump-down
    int    len;
    string tag;
  } exp_t;

  exp_t sbq[$];
  int   checks = 0, fails = 0, cyc = 0;
  bit   done = 1'b0, seen = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // Monitor: tracks driven intervals and checks them against the scoreboard.
  int run_kind = 0, run_start = 0, run_len = 0;
  bit bad_val = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      automatic int k = (up_oe && dn_oe) ? 3 : up_oe ? 1 : dn_oe ? 2 : 0;
      if (k != 0) seen = 1'b1;
      if (k == 3) chk(1'b0, "R9", "both driven", 3, 0);
      if ((k == 1 && !up_val) || (k == 2 && dn_val)) bad_val = 1'b1;
      if (k != run_kind) begin
        if (run_kind == 1 || run_kind == 2) begin
          if (sbq.size() == 0) begin
            chk(1'b0, "R4", "unexpected drive kind", run_kind, 0);
          end else begin
            automatic exp_t e = sbq.pop_front();
            chk(run_kind == e.kind, e.tag, "pump kind", run_kind, e.kind);
            chk(run_start == e.start, "R5", "drive start cycle", run_start, e.start);
            chk(run_len == e.len, "R5", "drive length", run_len, e.len);
            chk(!bad_val, "R9", "tied line level", int'(bad_val), 0);
          end
        end
        run_kind  = k;
        run_start = cyc;
        run_len   = 0;
        bad_val   = 1'b0;
      end
      if (k != 0) run_len++;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Window edge, then a read edge d clocks later.
  task automatic trial(input int d, input int kind, input string tag);
    int n;
    seen = 1'b0;
    @(negedge clk);
    win_clk = 1'b1;
    if (d > 0) step(d);
    rdat_n = 1'b0;
    n = cyc;
    if (kind != 0) sbq.push_back('{n + LAT, kind, PL, tag});
    step(1);
    rdat_n = 1'b1;
    step(1);
    win_clk = 1'b0;
    step(16);
    if (kind == 0) chk(!seen, tag, "output driven", int'(seen), 0);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired: actual %0d expected %0d", cyc, 0);
      report();
    end
  end

  initial begin
    step(4);
    rst = 1'b0;
    // R1 reset state
    chk(!up_oe && !dn_oe, "R1", "oe after reset", int'({up_oe, dn_oe}), 0);
    chk(!up_val && dn_val, "R1", "values after reset", int'({up_val, dn_val}), 1);
    step(4);

    trial(0,  1, "R2");   // coincident edges: early
    trial(3,  1, "R2");   // last early phase
    trial(4,  0, "R4");   // first centre phase
    trial(7,  0, "R4");   // last centre phase
    trial(8,  2, "R3");   // first late phase
    trial(20, 2, "R3");   // past the window: saturated late

    sep_inhibit = 1'b1;
    trial(1, 0, "R6");
    sep_inhibit = 1'b0;
    write_gate = 1'b1;
    trial(9, 0, "R6");
    write_gate = 1'b0;
    rgate_n = 1'b1;
    trial(1, 0, "R7");
    trial(10, 0, "R7");
    rgate_n = 1'b0;

    // R8: inhibit raised in the first driven cycle cuts the drive to one cycle
    begin
      int n;
      @(negedge clk);
      win_clk = 1'b1;
      step(1);
      rdat_n = 1'b0;
      n = cyc;
      sbq.push_back('{n + LAT, 1, 1, "R8"});
      step(1);
      rdat_n = 1'b1;
      step(LAT - 1);
      sep_inhibit = 1'b1;
      step(1);
      chk(!up_oe, "R8", "pump-up after inhibit", int'(up_oe), 0);
      step(3);
      sep_inhibit = 1'b0;
      win_clk = 1'b0;
      step(12);
    end

    trial(2, 1, "R2");    // normal operation resumes
    step(10);
    chk(sbq.size() == 0, "R5", "pending expected drives", sbq.size(), 0);
    done = 1'b1;
    report();
  end

endmodule